// File: doc/BRIEF.md
# Packet-Boundary Transmit Enable Gate

This block sits between the MAC-side transmit enable and the line transmitter. It forwards the MAC's transmit enable to the line only for whole packets. A software transmit-disable control, and a link-instability condition, can stop transmission. They never truncate a packet that is already on the wire. They also never let the tail of a packet out when the control releases in the middle of it. Each decision to send or block a packet is taken on the clock edge where TX_EN is first seen high. That decision is then held until TX_EN drops.

The same block also folds two control bits into the status path. A link-check enable either passes the raw link-good signal through, or forces the link-OK status and the link LED on. A carrier-integrity disable bit either lets an unstable-link indication shut the receive and transmit functions, or masks that indication completely. All outputs are registered, so each one responds one transmit-clock cycle after its inputs.

Top module: `pkt_tx_gate`

## Requirements
- R1: While reset is asserted, `txen_line`, `rxen`, `link_ok` and `link_led` are all 0.
- R2: A packet whose first TX_EN-high cycle is sampled while `sw_txoff` is 1 never appears on `txen_line`; the output stays 0 for the whole packet.
- R3: When the gate is open at a packet's first TX_EN-high cycle, `txen_line` is 1 from the following cycle and stays 1, one cycle behind TX_EN, until one cycle after TX_EN drops. This holds even if `sw_txoff` rises or the link turns unstable during the packet.
- R4: If `sw_txoff` falls while TX_EN is high, that packet stays blocked to its end. The next packet whose first TX_EN-high cycle sees the gate open is sent whole.
- R5: When `sw_txoff` is 0 and no unstable-link block applies, each TX_EN pulse is reproduced on `txen_line` delayed by exactly one cycle. This holds for single-cycle pulses and for back-to-back packets separated by one idle cycle.
- R6: When `lchk_en` is 0, `link_ok` and `link_led` are 1 one cycle later, whatever `link_raw` is.
- R7: When `lchk_en` is 1, `link_ok` and `link_led` follow `link_raw` with one cycle of delay.
- R8: When `cim_off` is 0 and `link_unstable` is 1, `rxen` is 0 one cycle later. A packet that starts under that condition is blocked for its whole length.
- R9: When `cim_off` is 1, `link_unstable` has no effect: `rxen` stays 1 and packets pass.
- R10: If TX_EN is already high when reset is released, that packet is treated as in progress and blocked; transmission starts only at the next rising TX_EN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_txen | input | 1 | Transmit enable from the MAC |
| sw_txoff | input | 1 | Software transmit-disable control |
| lchk_en | input | 1 | Link-check enable; 0 forces link OK |
| cim_off | input | 1 | Carrier-integrity disable; 1 masks instability |
| link_raw | input | 1 | Raw link-good indication |
| link_unstable | input | 1 | Unstable-link indication |
| txen_line | output | 1 | Gated transmit enable to the line transmitter |
| rxen | output | 1 | Receive function enable |
| link_ok | output | 1 | Link status (good at 100 Mb/s when forced) |
| link_led | output | 1 | Link LED drive |

## Verification
The only state the gate keeps is whether the previous cycle had TX_EN high, and whether the current packet was admitted. A wrong previous-TX_EN bit shows up at the first packet boundary. It appears either as an admitted fragment when a control clears mid-packet, or as a refused packet when no boundary was missed. A wrong admission bit appears on `txen_line` one cycle after the faulty edge. The bench compares every output in every cycle against an independent per-cycle expectation. A fault is therefore reported at the first cycle in which it differs at the ports. This includes reset release with TX_EN high, and single-cycle packets.

// File: rtl/pkt_tx_gate.sv
module pkt_tx_gate #(
  parameter bit TXEN_PRIOR_AT_RESET = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mac_txen,
  input  logic sw_txoff,
  input  logic lchk_en,
  input  logic cim_off,
  input  logic link_raw,
  input  logic link_unstable,
  output logic txen_line,
  output logic rxen,
  output logic link_ok,
  output logic link_led
);

  logic txen_prev;
  logic admitted;

  wire cim_block = link_unstable & ~cim_off;
  wire gate_open = ~sw_txoff & ~cim_block;
  wire pkt_start = mac_txen & ~txen_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txen_prev <= TXEN_PRIOR_AT_RESET;
      admitted  <= 1'b0;
    end else begin
      txen_prev <= mac_txen;
      if (!mac_txen)      admitted <= 1'b0;
      else if (pkt_start) admitted <= gate_open;
    end
  end

  assign txen_line = admitted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxen     <= 1'b0;
      link_ok  <= 1'b0;
      link_led <= 1'b0;
    end else begin
      rxen     <= ~cim_block;
      link_ok  <= lchk_en ? link_raw : 1'b1;
      link_led <= lchk_en ? link_raw : 1'b1;
    end
  end

  a_r2_start_blocked_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && sw_txoff) |=> !txen_line);

  a_r3_no_truncation: assert property (@(posedge clk) disable iff (!rst_n)
    (txen_line && mac_txen) |=> txen_line);

  a_r4_no_midpacket_start: assert property (@(posedge clk) disable iff (!rst_n)
    (txen_prev && mac_txen && !txen_line) |=> !txen_line);

  a_r5_ends_with_txen: assert property (@(posedge clk) disable iff (!rst_n)
    !mac_txen |=> !txen_line);

  a_r6_forced_link: assert property (@(posedge clk) disable iff (!rst_n)
    !lchk_en |=> (link_ok && link_led));

  a_r8_unstable_kills_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (link_unstable && !cim_off) |=> !rxen);

  a_r9_masked_instability: assert property (@(posedge clk) disable iff (!rst_n)
    cim_off |=> rxen);

endmodule

// File: tb/tb_pkt_tx_gate.sv
module tb_pkt_tx_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mac_txen = 1'b0, sw_txoff = 1'b0, lchk_en = 1'b1, cim_off = 1'b0;
  logic link_raw = 1'b0, link_unstable = 1'b0;
  logic txen_line, rxen, link_ok, link_led;

  always #4 clk = ~clk;

  pkt_tx_gate dut (
    .clk(clk), .rst_n(rst_n), .mac_txen(mac_txen), .sw_txoff(sw_txoff),
    .lchk_en(lchk_en), .cim_off(cim_off), .link_raw(link_raw),
    .link_unstable(link_unstable), .txen_line(txen_line), .rxen(rxen),
    .link_ok(link_ok), .link_led(link_led)
  );

  typedef struct {
    logic  tx;
    logic  rx;
    logic  lk;
    string req;
  } exp_t;

  exp_t  sb[$];
  int    compared = 0;
  int    mismatched = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  logic  m_prev = 1'b1;
  logic  m_tx = 1'b0;

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic step(input logic en);
    exp_t e;
    logic ok;
    mac_txen = en;
    @(posedge clk);
    ok = !sw_txoff && !(link_unstable && !cim_off);
    if (!en)          m_tx = 1'b0;
    else if (!m_prev) m_tx = ok;
    m_prev = en;
    e.tx  = m_tx;
    e.rx  = !(link_unstable && !cim_off);
    e.lk  = lchk_en ? link_raw : 1'b1;
    e.req = cur_req;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic pkt(input int len);
    for (int i = 0; i < len; i++) step(1'b1);
    step(1'b0);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      compared++;
      if (txen_line !== e.tx || rxen !== e.rx || link_ok !== e.lk || link_led !== e.lk) begin
        mismatched++;
        $display("FAIL %s: txen_line/rxen/link_ok/link_led = %b%b%b%b expected %b%b%b%b",
                 e.req, txen_line, rxen, link_ok, link_led, e.tx, e.rx, e.lk, e.lk);
      end
    end
  end

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
  end

  initial begin
    mac_txen = 1'b1;
    repeat (3) @(negedge clk);
    compared++;
    if ({txen_line, rxen, link_ok, link_led} !== 4'b0000) begin
      mismatched++;
      $display("FAIL R1: outputs in reset %b%b%b%b expected 0000",
               txen_line, rxen, link_ok, link_led);
    end
    rst_n = 1'b1;
    cur_req = "R10";
    repeat (4) step(1'b1);
    step(1'b0);
    pkt(3);

    cur_req = "R5";
    pkt(1); pkt(1); pkt(5);
    step(1'b0); step(1'b0);

    cur_req = "R2";
    sw_txoff = 1'b1;
    pkt(4); pkt(1);

    cur_req = "R4";
    step(1'b1); step(1'b1);
    sw_txoff = 1'b0;
    step(1'b1); step(1'b1);
    step(1'b0);
    pkt(3);

    cur_req = "R3";
    step(1'b1); step(1'b1);
    sw_txoff = 1'b1;
    step(1'b1); step(1'b1); step(1'b0);
    pkt(2);
    sw_txoff = 1'b0;
    step(1'b1);
    link_unstable = 1'b1;
    step(1'b1); step(1'b1); step(1'b0);

    cur_req = "R8";
    pkt(3);
    link_unstable = 1'b0;
    pkt(2);

    cur_req = "R9";
    cim_off = 1'b1;
    link_unstable = 1'b1;
    pkt(3);
    link_unstable = 1'b0;
    cim_off = 1'b0;

    cur_req = "R7";
    lchk_en = 1'b1;
    link_raw = 1'b1; step(1'b0); step(1'b0);
    link_raw = 1'b0; step(1'b0);
    link_raw = 1'b1; step(1'b0);

    cur_req = "R6";
    lchk_en = 1'b0;
    link_raw = 1'b0; step(1'b0); step(1'b0);
    link_raw = 1'b1; step(1'b0);
    link_raw = 1'b0; pkt(2);

    step(1'b0);
    @(negedge clk);
    report();
  end
endmodule